// File: doc/BRIEF.md
# Self-Timed Flash Program Control Register

This block is a single byte-wide control and status register that sequences one erase or write of a program-memory row. Software fills in a space-select bit, a row-erase bit and a write-enable bit, and starts the job by writing a 1 to the start bit. An internal counter then stands in for the programming time. For that whole interval the block raises `busy`, and in the first cycle it sends a one-cycle request strobe toward the flash array. When the count runs out, hardware clears the start bit itself.

The block raises an error flag when a job cannot run as asked. There are two such cases. The first is a start written while write enable is low, which is refused. The second is a warm reset that arrives during a running job, which aborts it. An abort leaves the space-select bit as it was, so software can still see which space the failed job targeted. A power-on reset clears every stored bit.

Top module: `flash_prog_ctrl`

## Requirements
- R1: Register layout: bit 6 = space select, bit 4 = row-erase enable, bit 3 = error flag, bit 2 = write enable, bit 1 = start. Bits 7, 5 and 0 always read 0, and writes to them are ignored.
- R2: While `porRstN` is low, all register bits are 0, `busy` is 0 and both request strobes are 0.
- R3: Only hardware clears the start bit. While `busy` is high, every register write is ignored, including a write of 0 to the start bit, and the readback does not change.
- R4: Take an idle write, with no warm reset, whose byte has bit 1 set. If bit 2 of the same byte is 1, a job launches and reads start=1 after that clock edge. If bit 2 is 0, no job launches: start stays 0 and the error flag reads 1. An idle write with bit 1 clear only loads the fields.
- R5: `busy` equals the start bit. It is high for exactly OP_CYCLES clock cycles, beginning at the clock edge that accepts the launching write.
- R6: In the first busy cycle only, exactly one strobe is high for one cycle: `eraseReq` if the erase bit is 1, otherwise `writeReq`.
- R7: When a job completes normally, the start, erase and error bits read 0. Space select and write enable keep their values.
- R8: A warm reset during a job aborts it. Start, erase and write enable clear, the error flag reads 1, `busy` drops at that edge, and space select is unchanged.
- R9: A warm reset while idle clears start, erase and write enable. It leaves the error flag and space select unchanged.
- R10: `cfgSel` always equals register bit 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low |
| warmRst | input | 1 | Synchronous warm reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Live register readback |
| busy | output | 1 | Self-timed job in progress |
| eraseReq | output | 1 | One-cycle row-erase request |
| writeReq | output | 1 | One-cycle row-write request |
| cfgSel | output | 1 | Space select: 1 = configuration space, 0 = program space |

## Verification
The start bit and the sequencer state are held in separate flops. If they disagree, `busy` and readback bit 1 differ in the same cycle. A counter that is loaded or decremented wrongly shows up at the falling edge of `busy`, which lands one or more cycles away from OP_CYCLES. A bad abort path, a bad completion path or a stuck erase bit shows in the readback on the first cycle after that event. The reference model compares every output on every cycle, so any divergence is reported no later than one clock after it appears.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;

  // Bit positions inside the control register. Software decodes these.
  localparam int CFG_BIT   = 6;
  localparam int ERASE_BIT = 4;
  localparam int ERR_BIT   = 3;
  localparam int WEN_BIT   = 2;
  localparam int START_BIT = 1;
  localparam int REG_W     = 8;

  // Strobes from the sequencer to the register datapath.
  typedef struct packed {
    logic accept;    // idle write is accepted
    logic launch;    // accepted write starts a job
    logic badStart;  // accepted write asks to start with write enable low
    logic finish;    // job counter expired
    logic abort;     // warm reset during a job
    logic warmIdle;  // warm reset while idle
  } ctrlStrobes_t;

endpackage

// File: rtl/flash_prog_ctrl_seq.sv
module flash_prog_ctrl_seq
  import flash_ctrl_pkg::*;
#(
  parameter int OP_CYCLES = 16
) (
  input  logic         clk,
  input  logic         porRstN,
  input  logic         warmRst,
  input  logic         wrEn,
  input  logic         wrStart,
  input  logic         wrWen,
  input  logic         eraseMode,
  output ctrlStrobes_t strb,
  output logic         busy,
  output logic         eraseReq,
  output logic         writeReq
);

  localparam int CNT_W = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(OP_CYCLES - 1);

  typedef enum logic {ST_IDLE, ST_RUN} seqState_t;

  seqState_t       state;
  logic [CNT_W-1:0] remain;
  logic             firstQ;

  // Decode this cycle's event from the inputs and the sequencer state.
  always_comb begin
    strb          = '0;
    strb.abort    = warmRst && (state == ST_RUN);
    strb.warmIdle = warmRst && (state == ST_IDLE);
    strb.finish   = !warmRst && (state == ST_RUN) && (remain == '0);
    strb.accept   = !warmRst && (state == ST_IDLE) && wrEn;
    strb.launch   = strb.accept && wrStart && wrWen;
    strb.badStart = strb.accept && wrStart && !wrWen;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      state  <= ST_IDLE;
      remain <= '0;
      firstQ <= 1'b0;
    end else begin
      firstQ <= strb.launch;
      if (strb.launch) begin
        state  <= ST_RUN;
        remain <= LOAD_VAL;
      end else if (strb.abort || strb.finish) begin
        state  <= ST_IDLE;
        remain <= '0;
      end else if (state == ST_RUN) begin
        remain <= remain - 1'b1;
      end
    end
  end

  assign busy     = (state == ST_RUN);
  assign eraseReq = firstQ && eraseMode;
  assign writeReq = firstQ && !eraseMode;

endmodule

// File: rtl/flash_prog_ctrl_regs.sv
module flash_prog_ctrl_regs
  import flash_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             porRstN,
  input  ctrlStrobes_t     strb,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             cfgSel,
  output logic             eraseMode
);

  localparam logic [REG_W-1:0] IMPL_MASK =
      (REG_W'(1) << CFG_BIT) | (REG_W'(1) << ERASE_BIT) |
      (REG_W'(1) << ERR_BIT) | (REG_W'(1) << WEN_BIT)   |
      (REG_W'(1) << START_BIT);

  logic [REG_W-1:0] ctrlReg;
  logic [REG_W-1:0] nextReg;

  always_comb begin
    nextReg = ctrlReg;
    if (strb.abort || strb.warmIdle) begin
      nextReg[START_BIT] = 1'b0;
      nextReg[ERASE_BIT] = 1'b0;
      nextReg[WEN_BIT]   = 1'b0;
      if (strb.abort) nextReg[ERR_BIT] = 1'b1;
    end else if (strb.finish) begin
      nextReg[START_BIT] = 1'b0;
      nextReg[ERASE_BIT] = 1'b0;
      nextReg[ERR_BIT]   = 1'b0;
    end else if (strb.accept) begin
      nextReg            = wrData;
      nextReg[START_BIT] = strb.launch;
      if (strb.badStart) nextReg[ERR_BIT] = 1'b1;
    end
    nextReg = nextReg & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) ctrlReg <= '0;
    else          ctrlReg <= nextReg;
  end

  assign rdData    = ctrlReg;
  assign cfgSel    = ctrlReg[CFG_BIT];
  assign eraseMode = ctrlReg[ERASE_BIT];

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_ctrl_pkg::*;
#(
  parameter int OP_CYCLES = 16
) (
  input  logic       clk,
  input  logic       porRstN,
  input  logic       warmRst,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       busy,
  output logic       eraseReq,
  output logic       writeReq,
  output logic       cfgSel
);

  ctrlStrobes_t strb;
  logic         eraseMode;

  flash_prog_ctrl_seq #(.OP_CYCLES(OP_CYCLES)) u_seq (
    .clk      (clk),
    .porRstN  (porRstN),
    .warmRst  (warmRst),
    .wrEn     (wrEn),
    .wrStart  (wrData[START_BIT]),
    .wrWen    (wrData[WEN_BIT]),
    .eraseMode(eraseMode),
    .strb     (strb),
    .busy     (busy),
    .eraseReq (eraseReq),
    .writeReq (writeReq)
  );

  flash_prog_ctrl_regs u_regs (
    .clk      (clk),
    .porRstN  (porRstN),
    .strb     (strb),
    .wrData   (wrData),
    .rdData   (rdData),
    .cfgSel   (cfgSel),
    .eraseMode(eraseMode)
  );

endmodule

// File: rtl/flash_prog_ctrl_chk.sv
module flash_prog_ctrl_chk #(
  parameter int OP_CYCLES = 16
) (
  input logic       clk,
  input logic       porRstN,
  input logic       warmRst,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       busy,
  input logic       eraseReq,
  input logic       writeReq,
  input logic       cfgSel
);

  int runLen;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)  runLen <= 0;
    else if (busy) runLen <= runLen + 1;
    else           runLen <= 0;
  end

  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!porRstN)
    (rdData & 8'hA1) == 8'h00);

  a_r5_busy_is_start: assert property (@(posedge clk) disable iff (!porRstN)
    busy == rdData[1]);

  a_r5_run_length: assert property (@(posedge clk) disable iff (!porRstN)
    (!busy && $past(busy) && !$past(warmRst)) |-> (runLen == OP_CYCLES));

  a_r6_strobe_onehot: assert property (@(posedge clk) disable iff (!porRstN)
    $onehot0({eraseReq, writeReq}));

  a_r6_strobe_first_cycle: assert property (@(posedge clk) disable iff (!porRstN)
    (eraseReq || writeReq) == $rose(busy));

  a_r4_refused_start: assert property (@(posedge clk) disable iff (!porRstN)
    (wrEn && !busy && !warmRst && ((wrData & 8'h06) == 8'h02)) |=> (!busy && rdData[3]));

  a_r8_abort_flags: assert property (@(posedge clk) disable iff (!porRstN)
    (busy && warmRst) |=> (!busy && rdData[3] && (rdData[4] == 1'b0) && (rdData[2] == 1'b0)));

  a_r8_abort_keeps_space: assert property (@(posedge clk) disable iff (!porRstN)
    (busy && warmRst) |=> $stable(cfgSel));

  a_r9_idle_warm_keeps_err: assert property (@(posedge clk) disable iff (!porRstN)
    (!busy && warmRst) |=> ($stable(rdData[3]) && $stable(cfgSel) && !busy));

  a_r3_busy_write_ignored: assert property (@(posedge clk) disable iff (!porRstN)
    (busy && wrEn && !warmRst) |=> $stable(rdData[6]));

  a_r10_space_pin: assert property (@(posedge clk) disable iff (!porRstN)
    cfgSel == rdData[6]);

endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk #(.OP_CYCLES(OP_CYCLES)) u_chk (
  .clk     (clk),
  .porRstN (porRstN),
  .warmRst (warmRst),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .rdData  (rdData),
  .busy    (busy),
  .eraseReq(eraseReq),
  .writeReq(writeReq),
  .cfgSel  (cfgSel)
);

// File: tb/sim_flash_prog_ctrl.sv
`timescale 1ns/1ps
module sim_flash_prog_ctrl;

  localparam int N = 16;

  logic       clk = 1'b0;
  logic       porRstN, warmRst, wrEn;
  logic [7:0] wrData;
  logic [7:0] rdData;
  logic       busy, eraseReq, writeReq, cfgSel;

  int  nChecks = 0;
  int  nFail   = 0;
  bit  cmpOn   = 1'b0;
  bit  done    = 1'b0;

  // Behavioural reference state
  bit mCfg, mFree, mErr, mWen, mStart, mFirst;
  int mRemain;

  always #2 clk = ~clk;

  flash_prog_ctrl #(.OP_CYCLES(N)) u0 (
    .clk(clk), .porRstN(porRstN), .warmRst(warmRst), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .busy(busy), .eraseReq(eraseReq),
    .writeReq(writeReq), .cfgSel(cfgSel)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] modelRd();
    return {1'b0, mCfg, 1'b0, mFree, mErr, mWen, mStart, 1'b0};
  endfunction

  always @(posedge clk) begin
    if (!porRstN) begin
      {mCfg, mFree, mErr, mWen, mStart, mFirst} = '0;
      mRemain = 0;
    end else if (warmRst) begin
      if (mStart) mErr = 1'b1;
      mStart = 0; mFree = 0; mWen = 0; mFirst = 0; mRemain = 0;
    end else begin
      mFirst = 0;
      if (mStart) begin
        if (mRemain == 1) begin
          mStart = 0; mFree = 0; mErr = 0; mRemain = 0;
        end else mRemain--;
      end else if (wrEn) begin
        mCfg = wrData[6]; mFree = wrData[4]; mErr = wrData[3]; mWen = wrData[2];
        if (wrData[1]) begin
          if (wrData[2]) begin mStart = 1; mRemain = N; mFirst = 1; end
          else mErr = 1;
        end
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmpOn && !done) begin
      check(rdData == modelRd(), "R1 readback vs model", rdData, modelRd());
      check(busy == mStart, "R5 busy vs model", busy, mStart);
      check(eraseReq == (mFirst && mFree), "R6 eraseReq vs model", eraseReq, mFirst && mFree);
      check(writeReq == (mFirst && !mFree), "R6 writeReq vs model", writeReq, mFirst && !mFree);
      check(cfgSel == mCfg, "R10 cfgSel vs model", cfgSel, mCfg);
    end
  end

  task automatic regWrite(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic warmPulse();
    warmRst = 1'b1;
    @(negedge clk);
    warmRst = 1'b0;
  endtask

  task automatic waitIdle(output int k);
    k = 0;
    while (busy && k < 100) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    int k;
    porRstN = 1'b0; warmRst = 1'b0; wrEn = 1'b0; wrData = 8'h00;
    repeat (3) @(negedge clk);
    check(rdData == 8'h00, "R2 reset readback", rdData, 0);
    check({busy, eraseReq, writeReq} == 3'b000, "R2 reset outputs", {busy, eraseReq, writeReq}, 0);
    porRstN = 1'b1;
    cmpOn = 1'b1;
    @(negedge clk);

    // Erase job, all fields written as 1
    regWrite(8'hFF);
    check(rdData == 8'h5E, "R4 launch readback", rdData, 8'h5E);
    check((rdData & 8'hA1) == 0, "R1 unused bits", rdData & 8'hA1, 0);
    check(eraseReq && !writeReq, "R6 erase strobe", {eraseReq, writeReq}, 2'b10);
    @(negedge clk);
    check(!eraseReq && busy, "R6 strobe one cycle", {eraseReq, busy}, 2'b01);
    regWrite(8'h00);
    check(rdData == 8'h5E && busy, "R3 busy write ignored", rdData, 8'h5E);
    waitIdle(k);
    check(3 + k - 1 == N, "R5 erase duration", 3 + k - 1, N);
    check(rdData == 8'h44, "R7 erase completion", rdData, 8'h44);

    // Write job, program space
    regWrite(8'h06);
    check(writeReq && !eraseReq && busy, "R6 write strobe", {writeReq, eraseReq, busy}, 3'b101);
    waitIdle(k);
    check(k == N, "R5 write duration", k, N);
    check(rdData == 8'h04, "R7 write completion", rdData, 8'h04);

    // Refused start
    regWrite(8'h02);
    check(rdData == 8'h08 && !busy, "R4 refused start", rdData, 8'h08);
    check(!writeReq && !eraseReq, "R4 no strobe", {writeReq, eraseReq}, 0);

    // Abort by warm reset
    regWrite(8'h56);
    check(rdData == 8'h56 && busy, "R4 launch erase cfg", rdData, 8'h56);
    repeat (4) @(negedge clk);
    warmPulse();
    check(rdData == 8'h48 && !busy, "R8 abort readback", rdData, 8'h48);
    check(cfgSel == 1'b1, "R8 space kept", cfgSel, 1);
    repeat (3) @(negedge clk);
    check(!busy && !eraseReq && !writeReq, "R8 stays stopped", busy, 0);

    // Warm reset while idle
    regWrite(8'h5C);
    check(rdData == 8'h5C && !busy, "R4 load without start", rdData, 8'h5C);
    warmPulse();
    check(rdData == 8'h48, "R9 idle warm reset", rdData, 8'h48);
    check(cfgSel == 1'b1, "R10 space pin high", cfgSel, 1);
    regWrite(8'h00);
    check(rdData == 8'h00 && cfgSel == 1'b0, "R10 space pin low", {rdData, cfgSel}, 0);

    // Erase job in program space
    regWrite(8'h16);
    check(eraseReq && busy, "R6 erase strobe program space", eraseReq, 1);
    waitIdle(k);
    check(rdData == 8'h04, "R7 erase clears enable", rdData, 8'h04);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule